// File: doc/BRIEF.md
# Frame Wake-Up Pattern Matcher

This block watches received frame data and decides whether a frame carries one of up to eight wake-up patterns. Frame bytes arrive as 32-bit dwords with start and end markers. The patterns live in an external 64 x 40-bit pattern memory, which the block reads through a single synchronous read port. The first two words of that memory give each pattern an enable bit and a start pointer. Every later word carries four pattern bytes and a control byte. The control byte holds a byte mask, a count of frame dwords to skip before the word is compared, and a flag that marks the pattern's last word.

For every accepted dword the block makes one pass of memory reads. It first reads the two header words, then the current word of each pattern in turn. Each pattern keeps its own word pointer and skip counter, so all enabled patterns move through the frame independently. When any pattern compares successfully on its last word, a sticky match flag is set. The flag drives the wake output while wake is enabled, and it stays set until the host clears it.

Top module: `wkp_matcher`

## Requirements
- R1: Bit n of byte 0 of memory word 0 enables pattern n; a pattern whose bit is 0 at the frame's first dword never produces a match in that frame.
- R2: Pattern n (n<4) starts at the word whose address is in bits [5:0] of byte n+1 of word 0; pattern n (n>=4) takes its start address from byte n-3 of word 1. Byte k of a memory word is bits [8k+7:8k].
- R3: In a pattern word, pattern byte n (bits [8n+15:8n+8]) is compared with frame dword byte n (bits [8n+7:8n]); byte 0 of a dword is the first byte received.
- R4: Control bits [3:0] are a per-byte mask. When mask bit n is 0, pattern byte n is excluded from the compare.
- R5: Control bits [6:4] give the number of frame dwords (0..7) that pass before the word is compared against the following dword.
- R6: Control bit 7 marks the last word of a pattern. A successful compare on such a word is a full match, even when frame data follows. A successful compare on any other word moves the pattern to the next memory address.
- R7: Every start-of-frame dword restarts all patterns at their start words, and it is itself the first dword compared. A failed compare stops the pattern for the rest of the frame. A pattern that has not completed by the end-of-frame dword has failed.
- R8: All patterns are tracked in parallel and independently. A full match on any one of them sets the match flag.
- R9: match_o is 0 after reset, is set by a full match, and holds until a cycle with clr_i high. If a clear and a full match fall in the same cycle, the flag stays set.
- R10: wake_o equals match_o while wake_en_i is 1, and is 0 while wake_en_i is 0.
- R11: A dword is taken only while the block is idle. The pass for one dword occupies the 12 clock edges that follow its acceptance, so dwords must be at least 12 cycles apart. The memory returns data on the cycle after an address is presented, and mem_addr_o is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dw_valid_i | input | 1 | Frame dword present |
| dw_sof_i | input | 1 | Dword is the first of a frame |
| dw_eof_i | input | 1 | Dword is the last of a frame |
| dw_data_i | input | 32 | Frame dword, byte 0 in bits [7:0] |
| mem_addr_o | output | 6 | Pattern memory read address |
| mem_rdata_i | input | 40 | Pattern memory read data, one cycle after the address |
| clr_i | input | 1 | Clears the match flag (write-one-to-clear pulse) |
| wake_en_i | input | 1 | Lets the match flag drive the wake output |
| match_o | output | 1 | Sticky match flag |
| wake_o | output | 1 | Wake request |

## Verification
The assertions assume that dw_valid_i never rises while a pass is still running. They also assume that the memory behind mem_addr_o answers with one cycle of latency and stays unchanged during a frame. The bench holds every dword for a single cycle and then waits out the full 12-edge pass before it offers the next one. It loads its memory model only while no frame is in flight, and it pulses the clear only between frames, apart from one directed case that lines the clear up with the cycle in which a hit is recorded. Random cases build patterns from slices of the frame they are matched against, with random skips and masks and occasional single-bit corruption, so that hits and misses both occur.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int NPAT   = 8;
  localparam int AW     = 6;
  localparam int WW     = 40;
  localparam int DWW    = 32;
  localparam int NBYTE  = DWW / 8;
  localparam int HDRW   = 2;
  localparam int PPW    = 4;
  localparam int SKW    = 3;
  localparam int PH_LAST = HDRW + NPAT;
  localparam int PHW    = $clog2(PH_LAST + 1);

  typedef logic [AW-1:0]  ptr_t;
  typedef logic [WW-1:0]  word_t;
  typedef logic [DWW-1:0] dword_t;
  typedef logic [SKW-1:0] skip_t;

  typedef struct packed {
    logic             eop;
    skip_t            skip;
    logic [NBYTE-1:0] mask;
  } ctl_t;
endpackage

// File: rtl/wkp_seq.sv
module wkp_seq
  import wkp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dw_valid_i,
  input  logic                dw_sof_i,
  input  logic                dw_eof_i,
  input  dword_t              dw_data_i,
  input  word_t               mem_rdata_i,
  input  ptr_t [NPAT-1:0]     lane_addr_i,
  output ptr_t                mem_addr_o,
  output logic [NPAT-1:0]     rx_o,
  output logic                sof_o,
  output logic                eof_o,
  output dword_t              dw_o,
  output logic [NPAT-1:0]     hdr_en_o,
  output ptr_t [NPAT-1:0]     hdr_ptr_o
);
  logic             busy_q;
  logic [PHW-1:0]   ph_q;
  dword_t           dw_q;
  logic             sof_q, eof_q;
  word_t            hdr_q [HDRW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      dw_q   <= '0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
    end else if (!busy_q) begin
      if (dw_valid_i) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        dw_q   <= dw_data_i;
        sof_q  <= dw_sof_i;
        eof_q  <= dw_eof_i;
      end
    end else if (ph_q == PHW'(PH_LAST)) begin
      busy_q <= 1'b0;
    end else begin
      ph_q <= ph_q + PHW'(1);
    end
  end

  // header words land one cycle after their address
  for (genvar h = 0; h < HDRW; h++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                hdr_q[h] <= '0;
      else if (busy_q && ph_q == PHW'(h + 1))     hdr_q[h] <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_addr_o = '0;
    if (busy_q) begin
      for (int h = 0; h < HDRW; h++)
        if (ph_q == PHW'(h)) mem_addr_o = AW'(h);
      for (int p = 0; p < NPAT; p++)
        if (ph_q == PHW'(HDRW + p)) mem_addr_o = lane_addr_i[p];
    end
  end

  for (genvar p = 0; p < NPAT; p++) begin : g_lane
    assign rx_o[p]      = busy_q && (ph_q == PHW'(HDRW + 1 + p));
    assign hdr_ptr_o[p] = hdr_q[p / PPW][8 * (p % PPW + 1) +: AW];
  end

  assign hdr_en_o = hdr_q[0][NPAT-1:0];
  assign sof_o    = sof_q;
  assign eof_o    = eof_q;
  assign dw_o     = dw_q;

  logic unused_hdr;
  always_comb begin
    unused_hdr = ^hdr_q[1][7:0];
    for (int h = 0; h < HDRW; h++)
      for (int k = 1; k <= PPW; k++)
        unused_hdr = unused_hdr ^ (^hdr_q[h][8*k+AW +: 8-AW]);
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_valid_i |-> !busy_q); // R11
endmodule

// File: rtl/wkp_lane.sv
module wkp_lane
  import wkp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rx_i,
  input  logic   sof_i,
  input  logic   eof_i,
  input  logic   en_i,
  input  ptr_t   hdr_ptr_i,
  input  word_t  word_i,
  input  dword_t dw_i,
  output ptr_t   addr_o,
  output logic   hit_o
);
  ptr_t  ptr_q, ptr_eff;
  skip_t skc_q, skc_eff;
  logic  act_q, act_eff;
  ctl_t  ctl;
  logic  cmp_ok, cmp_now;

  assign ptr_eff = sof_i ? hdr_ptr_i : ptr_q;
  assign skc_eff = sof_i ? '0 : skc_q;
  assign act_eff = sof_i ? en_i : act_q;
  assign ctl     = ctl_t'(word_i[7:0]);
  assign addr_o  = ptr_eff;

  always_comb begin
    cmp_ok = 1'b1;
    for (int n = 0; n < NBYTE; n++)
      if (ctl.mask[n] && (word_i[8*n+8 +: 8] != dw_i[8*n +: 8])) cmp_ok = 1'b0;
  end

  assign cmp_now = rx_i && act_eff && (skc_eff == ctl.skip);
  assign hit_o   = cmp_now && cmp_ok && ctl.eop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      skc_q <= '0;
      act_q <= 1'b0;
    end else if (rx_i) begin
      if (eof_i || !act_eff) begin
        act_q <= 1'b0;
      end else if (skc_eff != ctl.skip) begin
        skc_q <= skc_eff + skip_t'(1);
        ptr_q <= ptr_eff;
        act_q <= 1'b1;
      end else if (!cmp_ok || ctl.eop) begin
        act_q <= 1'b0;
      end else begin
        ptr_q <= ptr_eff + ptr_t'(1);
        skc_q <= '0;
        act_q <= 1'b1;
      end
    end
  end

  AST_EOF_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_i && eof_i) |=> !act_q); // R7
endmodule

// File: rtl/wkp_status.sv
module wkp_status
  import wkp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPAT-1:0] hit_i,
  input  logic            clr_i,
  input  logic            wake_en_i,
  output logic            match_o,
  output logic            wake_o
);
  logic match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_q <= 1'b0;
    else if (|hit_i) match_q <= 1'b1;
    else if (clr_i)  match_q <= 1'b0;
  end

  assign match_o = match_q;
  assign wake_o  = match_q & wake_en_i;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> match_o); // R9
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clr_i) |=> match_o); // R9
  AST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|hit_i)) |=> !match_o); // R9
endmodule

// File: rtl/wkp_matcher.sv
module wkp_matcher
  import wkp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dw_valid_i,
  input  logic        dw_sof_i,
  input  logic        dw_eof_i,
  input  logic [31:0] dw_data_i,
  output logic [5:0]  mem_addr_o,
  input  logic [39:0] mem_rdata_i,
  input  logic        clr_i,
  input  logic        wake_en_i,
  output logic        match_o,
  output logic        wake_o
);
  ptr_t [NPAT-1:0] lane_addr;
  ptr_t [NPAT-1:0] hdr_ptr;
  logic [NPAT-1:0] rx, hdr_en, hit;
  logic            sof, eof;
  dword_t          dw;

  wkp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dw_valid_i  (dw_valid_i),
    .dw_sof_i    (dw_sof_i),
    .dw_eof_i    (dw_eof_i),
    .dw_data_i   (dw_data_i),
    .mem_rdata_i (mem_rdata_i),
    .lane_addr_i (lane_addr),
    .mem_addr_o  (mem_addr_o),
    .rx_o        (rx),
    .sof_o       (sof),
    .eof_o       (eof),
    .dw_o        (dw),
    .hdr_en_o    (hdr_en),
    .hdr_ptr_o   (hdr_ptr)
  );

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    wkp_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_i      (rx[p]),
      .sof_i     (sof),
      .eof_i     (eof),
      .en_i      (hdr_en[p]),
      .hdr_ptr_i (hdr_ptr[p]),
      .word_i    (mem_rdata_i),
      .dw_i      (dw),
      .addr_o    (lane_addr[p]),
      .hit_o     (hit[p])
    );
  end

  wkp_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .clr_i     (clr_i),
    .wake_en_i (wake_en_i),
    .match_o   (match_o),
    .wake_o    (wake_o)
  );

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R8
endmodule

// File: tb/sim_wkp_matcher.sv
`timescale 1ns/1ps
module sim_wkp_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv = 1'b0, dsof = 1'b0, deof = 1'b0, clr = 1'b0, wen = 1'b0;
  logic [31:0] dd = '0;
  logic [5:0]  maddr;
  logic [39:0] mrd = '0;
  logic        match, wake;

  logic [39:0] mem [64];
  logic [31:0] fr [32];
  int          fl;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) mrd <= mem[maddr];

  wkp_matcher u0 (
    .clk_i(clk), .rst_ni(rst_n), .dw_valid_i(dv), .dw_sof_i(dsof), .dw_eof_i(deof),
    .dw_data_i(dd), .mem_addr_o(maddr), .mem_rdata_i(mrd), .clr_i(clr),
    .wake_en_i(wen), .match_o(match), .wake_o(wake));

  function automatic logic [39:0] mk(bit eop, int skip, int mask, logic [31:0] pat);
    return {pat, eop, 3'(skip), 4'(mask)};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic mem_reset(logic [7:0] en);
    for (int a = 0; a < 64; a++) mem[a] = '0;
    mem[0][7:0] = en;
    for (int p = 0; p < 8; p++) begin
      if (p < 4) mem[0][8*(p+1) +: 8] = 8'(2 + 7*p);
      else       mem[1][8*(p-3) +: 8] = 8'(2 + 7*p);
    end
  endtask

  task automatic send_frame();
    for (int i = 0; i < fl; i++) begin
      @(negedge clk);
      dv = 1'b1; dsof = (i == 0); deof = (i == fl-1); dd = fr[i];
      @(posedge clk);
      @(negedge clk);
      dv = 1'b0; dsof = 1'b0; deof = 1'b0;
      repeat (11) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  function automatic logic ref_match();
    logic       any, act, ok;
    logic [5:0] ptr;
    logic [39:0] w;
    int         skc;
    any = 1'b0;
    for (int p = 0; p < 8; p++) begin
      act = mem[0][p];
      ptr = (p < 4) ? mem[0][8*(p+1) +: 6] : mem[1][8*(p-3) +: 6];
      skc = 0;
      for (int i = 0; i < fl; i++) begin
        if (act) begin
          w = mem[ptr];
          if (skc < int'(w[6:4])) skc++;
          else begin
            ok = 1'b1;
            for (int n = 0; n < 4; n++)
              if (w[n] && w[8*n+8 +: 8] != fr[i][8*n +: 8]) ok = 1'b0;
            if (!ok) act = 1'b0;
            else if (w[7]) begin any = 1'b1; act = 1'b0; end
            else begin ptr = ptr + 6'd1; skc = 0; end
          end
        end
      end
    end
    return any;
  endfunction

  task automatic base_frame();
    fl = 3; fr[0] = 32'h11223344; fr[1] = 32'h55667788; fr[2] = 32'h99aabbcc;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mem_reset(8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset match", match, 1'b0);
    chk("R10 reset wake", wake, 1'b0);
    chk("R11 idle addr", maddr == 6'd0, 1'b1);
    rst_n = 1'b1;

    // R3 single word full compare on first dword
    mem_reset(8'h01);
    mem[2] = mk(1, 0, 4'hF, 32'h11223344);
    base_frame(); wen = 1'b1;
    send_frame();
    chk("R3 full word match", match, 1'b1);
    chk("R10 wake enabled", wake, 1'b1);
    wen = 1'b0; @(negedge clk);
    chk("R10 wake disabled", wake, 1'b0);

    // R9 sticky across non-matching frame, then clear
    fl = 2; fr[0] = 32'h0; fr[1] = 32'h1;
    send_frame();
    chk("R9 sticky", match, 1'b1);
    pulse_clr();
    chk("R9 clear", match, 1'b0);

    // R1 disabled pattern
    mem[0][7:0] = 8'hFE; base_frame();
    send_frame();
    chk("R1 disabled", match, 1'b0);

    // R4 masks
    mem_reset(8'h01);
    mem[2] = mk(1, 0, 3, 32'hABCD3344); base_frame();
    send_frame();
    chk("R4 masked bytes ignored", match, 1'b1);
    pulse_clr();
    mem[2] = mk(1, 0, 3, 32'h11223345);
    send_frame();
    chk("R4 unmasked byte mismatch", match, 1'b0);

    // R5 skip
    mem[2] = mk(1, 2, 4'hF, 32'h99aabbcc); base_frame();
    send_frame();
    chk("R5 skip two", match, 1'b1);
    pulse_clr();
    fl = 3; fr[0] = 32'h99aabbcc; fr[1] = 32'h0; fr[2] = 32'h12345678;
    send_frame();
    chk("R5 skipped dword not compared", match, 1'b0);

    // R6 two-word chain, frame longer than pattern
    mem[2] = mk(0, 0, 4'hF, 32'h11223344);
    mem[3] = mk(1, 0, 4'hF, 32'h55667788);
    fl = 5; fr[0] = 32'h11223344; fr[1] = 32'h55667788; fr[2] = 32'h1; fr[3] = 32'h2; fr[4] = 32'h3;
    send_frame();
    chk("R6 chain partial frame", match, 1'b1);
    pulse_clr();

    // R7 incomplete at end of frame, then restart at next frame
    fl = 1; fr[0] = 32'h11223344;
    send_frame();
    chk("R7 incomplete at eof", match, 1'b0);
    fl = 2; fr[0] = 32'h55667788; fr[1] = 32'h11223344;
    send_frame();
    chk("R7 restart at sof", match, 1'b0);

    // R2 pattern 6 pointer from word 1
    mem_reset(8'h40);
    mem[44] = mk(1, 0, 4'hF, 32'h11223344); base_frame();
    send_frame();
    chk("R2 pattern 6 pointer", match, 1'b1);
    pulse_clr();

    // R8 two patterns, one fails, one matches after a skip
    mem_reset(8'h0A);
    mem[9]  = mk(1, 0, 4'hF, 32'hdeadbeef);
    mem[23] = mk(1, 1, 4'hF, 32'h55667788); base_frame();
    send_frame();
    chk("R8 parallel patterns", match, 1'b1);
    pulse_clr();

    // R9 clear coinciding with hit: set wins
    mem_reset(8'h01);
    mem[2] = mk(1, 0, 4'hF, 32'h11223344);
    @(negedge clk); dv = 1'b1; dsof = 1'b1; deof = 1'b1; dd = 32'h11223344;
    @(posedge clk);
    @(negedge clk); dv = 1'b0; dsof = 1'b0; deof = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 set wins over clear", match, 1'b1);
    pulse_clr();

    // R8 random patterns cut from the frame
    for (int it = 0; it < 40; it++) begin
      logic e;
      fl = 4 + int'($urandom % 9);
      for (int i = 0; i < fl; i++) fr[i] = $urandom;
      mem_reset(8'($urandom));
      for (int p = 0; p < 8; p++) begin
        int nw, cur, s;
        logic [31:0] src;
        nw = 1 + int'($urandom % 3); cur = 0;
        for (int k = 0; k < nw; k++) begin
          s = int'($urandom % 3); cur += s;
          src = (cur < fl) ? fr[cur] : $urandom;
          if ($urandom % 4 == 0) src ^= 32'h1 << ($urandom % 32);
          mem[2 + 7*p + k] = mk(k == nw-1, s, int'($urandom % 16), src);
          cur++;
        end
      end
      wen = 1'($urandom);
      pulse_clr();
      send_frame();
      e = ref_match();
      chk("R8 random match", match, e);
      chk("R10 random wake", wake, e & wen);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule